// File: doc/BRIEF.md
# Sticky Diagnostic Status Register Bank

This block gathers error events from analog-input comparators and digital integrity monitors into a small bank of registers. A host reaches the bank over a plain register bus with address, write data, write strobe, read strobe and read data. The read data is combinational, so it is valid in the same cycle as the read strobe. Each kind of flag has its own clearing rule.

A reset-detect flag records that a reset happened. Only a read of the status register clears it. Overvoltage and undervoltage errors latch per channel while that channel's checker is enabled. Writing a 1 to an error bit clears it, and so does turning off that channel's checker. Digital monitor errors latch one bit per monitor and also clear on a written 1. The OR of the monitor bits forms a summary error bit. The summary bit and the reset-detect flag are both driven on a status-header output, so the host can see them without a register access.

In every clearing rule, an event that arrives in the same cycle as a clear takes priority. No event is lost to a race with software.

Top module: `diag_status_bank`

## Requirements
- R1: After `rst_n` is released, the reset-detect flag reads 1. The enable register, both channel error registers and the monitor register read 0.
- R2: A read of address 0x01 returns the reset-detect flag in bit 7 and the summary error in bit 6, with all other bits 0. The read clears the reset-detect flag at the following clock edge.
- R3: A write to address 0x01 changes nothing. The reset-detect flag keeps its value.
- R4: A pulse on `reset_seen` sets the reset-detect flag. If that pulse coincides with a status read, the read returns 1 in bit 7 and the flag stays set.
- R5: Address 0x25 is the checker-enable register. It reads back what was written, and bit n enables the checkers of channel n.
- R6: An overvoltage event on an enabled channel n sets bit n of address 0x26. The bit stays set after the event ends. An event on a disabled channel leaves the register unchanged.
- R7: An undervoltage event on an enabled channel n sets bit n of address 0x27. The bit stays set after the event ends. An event on a disabled channel leaves the register unchanged.
- R8: Writing to 0x26 or 0x27 clears every bit written as 1 and leaves every bit written as 0 alone. If an event for a bit arrives in the same cycle as its clear, the bit stays set.
- R9: Clearing bit n of the enable register clears bit n of both 0x26 and 0x27.
- R10: Address 0x22 latches the monitor events, one bit per monitor:
  - bit 0: ROM CRC
  - bit 1: register-map CRC
  - bit 2: interface CRC
  - bit 3: invalid bus access
  - bit 4: busy stuck high

  A written 1 clears a bit. An event that coincides with the clear keeps the bit set.
- R11: The summary error is the OR of the bits of 0x22. It appears on `hdr_dig_err` and in status bit 6. `hdr_reset_det` follows the reset-detect flag.
- R12: A read of any address other than 0x01, 0x22, 0x25, 0x26 or 0x27 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_seen | input | 1 | Pulse reporting a partial or full reset |
| ov_evt | input | NUM_CH | Overvoltage comparator outputs, one per channel |
| uv_evt | input | NUM_CH | Undervoltage comparator outputs, one per channel |
| mon_evt | input | NUM_MON | Digital monitor event outputs |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; status read clears the reset flag |
| rdata | output | DATA_W | Combinational read data |
| hdr_reset_det | output | 1 | Status-header reset-detect bit |
| hdr_dig_err | output | 1 | Status-header summary digital error bit |

## Verification
The assertions assume that the bus carries at most one read or one write per cycle. They also assume that a change to the enable register never coincides with a comparator event on the channel being changed. The bench keeps within these assumptions by driving writes, reads and event pulses from separate tasks. It starts an event in the same cycle as a write only when it is deliberately testing the set-over-clear rule on the error registers. Every enable pattern is swept with all comparator inputs pulsed, and each channel and monitor is walked alone.

// File: rtl/diag_status_bank.sv
module diag_status_bank #(
  parameter int NUM_CH  = 8,
  parameter int NUM_MON = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] A_STATUS = 8'h01,
  parameter logic [ADDR_W-1:0] A_MON    = 8'h22,
  parameter logic [ADDR_W-1:0] A_EN     = 8'h25,
  parameter logic [ADDR_W-1:0] A_OV     = 8'h26,
  parameter logic [ADDR_W-1:0] A_UV     = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_seen,
  input  logic [NUM_CH-1:0] ov_evt,
  input  logic [NUM_CH-1:0] uv_evt,
  input  logic [NUM_MON-1:0] mon_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              hdr_reset_det,
  output logic              hdr_dig_err
);

  logic              rst_flag;
  logic [NUM_CH-1:0] en_q, ov_q, uv_q;
  logic [NUM_MON-1:0] mon_q;

  wire rd_status = rd_en && (addr == A_STATUS);
  wire wr_mon    = wr_en && (addr == A_MON);
  wire wr_enr    = wr_en && (addr == A_EN);
  wire wr_ov     = wr_en && (addr == A_OV);
  wire wr_uv     = wr_en && (addr == A_UV);

  wire [NUM_CH-1:0]  en_nxt  = wr_enr ? wdata[NUM_CH-1:0] : en_q;
  wire [NUM_CH-1:0]  ov_clr  = wr_ov  ? wdata[NUM_CH-1:0] : '0;
  wire [NUM_CH-1:0]  uv_clr  = wr_uv  ? wdata[NUM_CH-1:0] : '0;
  wire [NUM_MON-1:0] mon_clr = wr_mon ? wdata[NUM_MON-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_flag <= 1'b1;
      en_q     <= '0;
      ov_q     <= '0;
      uv_q     <= '0;
      mon_q    <= '0;
    end else begin
      if (reset_seen)     rst_flag <= 1'b1;
      else if (rd_status) rst_flag <= 1'b0;
      en_q  <= en_nxt;
      ov_q  <= en_nxt & ((ov_q & ~ov_clr) | ov_evt);
      uv_q  <= en_nxt & ((uv_q & ~uv_clr) | uv_evt);
      mon_q <= (mon_q & ~mon_clr) | mon_evt;
    end
  end

  assign hdr_reset_det = rst_flag;
  assign hdr_dig_err   = |mon_q;

  always_comb begin
    rdata = '0;
    if (addr == A_STATUS) begin
      rdata[DATA_W-1] = rst_flag | reset_seen;
      rdata[DATA_W-2] = hdr_dig_err;
    end else if (addr == A_MON) rdata = DATA_W'(mon_q);
    else if (addr == A_EN)      rdata = DATA_W'(en_q);
    else if (addr == A_OV)      rdata = DATA_W'(ov_q);
    else if (addr == A_UV)      rdata = DATA_W'(uv_q);
  end

endmodule

// File: rtl/diag_status_bank_chk.sv
module diag_status_bank_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_MON = 5,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] A_STATUS = 8'h01,
  parameter logic [ADDR_W-1:0] A_EN     = 8'h25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reset_seen,
  input logic [NUM_CH-1:0] ov_evt,
  input logic [NUM_CH-1:0] uv_evt,
  input logic [NUM_MON-1:0] mon_evt,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              hdr_reset_det,
  input logic              hdr_dig_err,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] ov_q,
  input logic [NUM_CH-1:0] uv_q
);

  wire rd_st  = rd_en && (addr == A_STATUS);
  wire wr_enr = wr_en && (addr == A_EN);

  // R2
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !reset_seen) |=> !hdr_reset_det);

  // R3
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_reset_det && !rd_st) |=> hdr_reset_det);

  // R4
  reset_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> hdr_reset_det);

  // R6
  ov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_enr && |(ov_evt & en_q)) |=> ((ov_q & $past(ov_evt & en_q)) == $past(ov_evt & en_q)));

  // R7
  uv_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_enr && |(uv_evt & en_q)) |=> ((uv_q & $past(uv_evt & en_q)) == $past(uv_evt & en_q)));

  // R9
  ov_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q & ~en_q) == '0);

  // R9
  uv_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_q & ~en_q) == '0);

  // R11
  mon_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mon_evt) |=> hdr_dig_err);

endmodule

bind diag_status_bank diag_status_bank_chk #(
  .NUM_CH(NUM_CH), .NUM_MON(NUM_MON), .ADDR_W(ADDR_W),
  .A_STATUS(A_STATUS), .A_EN(A_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_seen(reset_seen),
  .ov_evt(ov_evt), .uv_evt(uv_evt), .mon_evt(mon_evt),
  .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .hdr_reset_det(hdr_reset_det), .hdr_dig_err(hdr_dig_err),
  .en_q(en_q), .ov_q(ov_q), .uv_q(uv_q)
);

// File: tb/diag_status_bank_tb.sv
module diag_status_bank_tb;
  logic clk = 0, rst_n = 0, reset_seen = 0, wr_en = 0, rd_en = 0;
  logic [7:0] ov_evt = 0, uv_evt = 0, addr = 0, wdata = 0;
  logic [4:0] mon_evt = 0;
  logic [7:0] rdata;
  logic hdr_reset_det, hdr_dig_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  diag_status_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reset_seen(reset_seen),
    .ov_evt(ov_evt), .uv_evt(uv_evt), .mon_evt(mon_evt),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .hdr_reset_det(hdr_reset_det), .hdr_dig_err(hdr_dig_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [7:0] ov, input logic [7:0] uv, input logic [4:0] mon, input logic rs);
    @(negedge clk); ov_evt = ov; uv_evt = uv; mon_evt = mon; reset_seen = rs;
    @(negedge clk); ov_evt = 0; uv_evt = 0; mon_evt = 0; reset_seen = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", {7'b0, hdr_reset_det}, 8'h01);
    chk("R1 summary", {7'b0, hdr_dig_err}, 8'h00);
    rd(8'h25, d); chk("R1 en", d, 8'h00);
    rd(8'h26, d); chk("R1 ov", d, 8'h00);
    rd(8'h27, d); chk("R1 uv", d, 8'h00);
    rd(8'h22, d); chk("R1 mon", d, 8'h00);

    wr(8'h01, 8'h00); wr(8'h01, 8'hFF);
    chk("R3 write ignored", {7'b0, hdr_reset_det}, 8'h01);
    rd(8'h01, d); chk("R2 status read", d, 8'h80);
    chk("R2 cleared", {7'b0, hdr_reset_det}, 8'h00);
    rd(8'h01, d); chk("R2 second read", d, 8'h00);

    pulse(0, 0, 0, 1);
    chk("R4 set", {7'b0, hdr_reset_det}, 8'h01);
    rd(8'h01, d);
    @(negedge clk); addr = 8'h01; rd_en = 1; reset_seen = 1;
    #1 chk("R4 coincident read", rdata, 8'h80);
    @(negedge clk); rd_en = 0; reset_seen = 0;
    chk("R4 stays set", {7'b0, hdr_reset_det}, 8'h01);
    rd(8'h01, d);

    foreach (d[i]) begin end
    for (int p = 0; p < 256; p += 37) begin
      wr(8'h25, p[7:0]); rd(8'h25, d); chk("R5 enable readback", d, p[7:0]);
    end

    wr(8'h25, 8'hFF);
    for (int ch = 0; ch < 8; ch++) begin
      logic [7:0] b;
      b = 8'(1 << ch);
      pulse(b, 0, 0, 0);
      rd(8'h26, d); chk("R6 ov channel", d, b);
      rd(8'h27, d); chk("R7 uv untouched", d, 8'h00);
      wr(8'h26, ~b); rd(8'h26, d); chk("R8 zero keeps ov", d, b);
      wr(8'h26, b);  rd(8'h26, d); chk("R8 one clears ov", d, 8'h00);
      pulse(0, b, 0, 0);
      rd(8'h27, d); chk("R7 uv channel", d, b);
      wr(8'h27, ~b); rd(8'h27, d); chk("R8 zero keeps uv", d, b);
      wr(8'h27, b);  rd(8'h27, d); chk("R8 one clears uv", d, 8'h00);
    end

    for (int m = 0; m < 256; m++) begin
      wr(8'h25, m[7:0]);
      pulse(8'hFF, 8'hFF, 0, 0);
      rd(8'h26, d); chk("R6 enabled mask", d, m[7:0]);
      rd(8'h27, d); chk("R7 enabled mask", d, m[7:0]);
      wr(8'h25, 8'h00);
      rd(8'h26, d); chk("R9 disable clears ov", d, 8'h00);
      rd(8'h27, d); chk("R9 disable clears uv", d, 8'h00);
    end

    wr(8'h25, 8'hFF);
    pulse(8'hFF, 8'hFF, 0, 0);
    wr(8'h25, 8'hF0);
    rd(8'h26, d); chk("R9 partial ov", d, 8'hF0);
    rd(8'h27, d); chk("R9 partial uv", d, 8'hF0);

    wr(8'h25, 8'hFF);
    wr(8'h26, 8'hFF);
    pulse(8'h03, 0, 0, 0);
    @(negedge clk); addr = 8'h26; wdata = 8'h03; wr_en = 1; ov_evt = 8'h01;
    @(negedge clk); wr_en = 0; ov_evt = 0;
    rd(8'h26, d); chk("R8 event wins ov", d, 8'h01);
    wr(8'h27, 8'hFF);
    pulse(0, 8'h0C, 0, 0);
    @(negedge clk); addr = 8'h27; wdata = 8'h0C; wr_en = 1; uv_evt = 8'h08;
    @(negedge clk); wr_en = 0; uv_evt = 0;
    rd(8'h27, d); chk("R8 event wins uv", d, 8'h08);

    for (int k = 0; k < 5; k++) begin
      logic [4:0] b;
      b = 5'(1 << k);
      pulse(0, 0, b, 0);
      chk("R11 header summary set", {7'b0, hdr_dig_err}, 8'h01);
      rd(8'h22, d); chk("R10 monitor bit", d, {3'b0, b});
      rd(8'h01, d); chk("R11 status summary", d, 8'h40);
      wr(8'h22, 8'(~b)); rd(8'h22, d); chk("R10 zero keeps", d, {3'b0, b});
      wr(8'h22, {3'b0, b});
      chk("R11 header summary clear", {7'b0, hdr_dig_err}, 8'h00);
      rd(8'h22, d); chk("R10 cleared", d, 8'h00);
    end
    pulse(0, 0, 5'h11, 0);
    @(negedge clk); addr = 8'h22; wdata = 8'h11; wr_en = 1; mon_evt = 5'h10;
    @(negedge clk); wr_en = 0; mon_evt = 0;
    rd(8'h22, d); chk("R10 event wins", d, 8'h10);

    chk("R12 state present", {7'b0, hdr_dig_err}, 8'h01);
    rd(8'h00, d); chk("R12 addr 00", d, 8'h00);
    rd(8'h02, d); chk("R12 addr 02", d, 8'h00);
    rd(8'h23, d); chk("R12 addr 23", d, 8'h00);
    rd(8'h28, d); chk("R12 addr 28", d, 8'h00);
    rd(8'hA6, d); chk("R12 addr A6", d, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule